// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block is the interrupt unit that sits beside a small 8-bit processor core. It gathers twelve maskable request sources and the reset request. It keeps the interrupt state the core needs, and it tells the core which handler to enter and at which program address. Two of the sources are external request pins. Five are timer events. These seven have a latched pending flag and an enable bit, and both sit in a mask register and a flag register that the core reaches over a small register bus. The other five sources are serial, UART and comparator requests. They are level signals, each with its own enable input, and the peripheral drops the request itself once it has been served.

A global enable bit gates every maskable request. When the core raises its instruction-boundary strobe, the block chooses the pending source with the lowest vector number. It then holds that vector number and the handler address on its outputs until the core acknowledges them. An acknowledge clears the global enable and clears the flag of the source being served. The return command sets the global enable again, and separate set and clear commands let software control the bit directly. After reset, the reset vector is presented at the first boundary whatever the state of the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Reset state. After reset the global enable is 0, all mask and flag bits are 0 and no vector is presented. At the first boundary strobe vector 0 is presented even though the global enable is 0. Acknowledging vector 0 retires this reset request.
- R2: A pulse on an external or timer event input sets its flag on the next clock edge, whatever its mask bit holds. The flags read back at address 1 (external, bit i = external source i) and at address 3 (timer, bit i = timer source i). A flag only falls through a write-one clear or through an acknowledge.
- R3: Writing address 1 or 3 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. An event arriving in the same cycle as the clear wins, and its flag stays 1.
- R4: The external mask is read and written at address 0, bits 1:0. The timer mask is read and written at address 2, bits 4:0. All unused read bits are 0.
- R5: A vector is presented only when the boundary strobe is high, the global enable is 1 and at least one source has (flag AND mask) or (level AND enable) set. The valid output rises on the clock edge that samples the strobe. A strobe with nothing qualifying drops the valid output.
- R6: The winner is the lowest vector number among the qualifying sources. Vectors 1 and 2 are external sources 0 and 1. Vectors 3 to 7 are timer sources 0 to 4. Vectors 8 to 12 are level sources 0 to 4.
- R7: The presented address equals VEC_BASE + vector × VEC_STRIDE, computed in ADDR_W bits.
- R8: An acknowledge while a vector is presented drops the valid output, clears the global enable and clears the flag of the vector's source on the same edge, unless a new event for that source arrives in that cycle. An acknowledge while no vector is presented has no effect.
- R9: Level sources are never cleared by the block. A level request that stays high is presented again at the next qualifying boundary.
- R10: The clear command clears the global enable. The set and return commands set it. When several arrive together, an accepted acknowledge beats the clear command, and the clear command beats the set and return commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 ext mask, 1 ext flag, 2 timer mask, 3 timer flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ext_evt | input | NUM_EXT (2) | External event pulses |
| tmr_evt | input | NUM_TMR (5) | Timer event pulses |
| lvl_req | input | NUM_LVL (5) | Level requests from serial, UART and comparator |
| lvl_en | input | NUM_LVL (5) | Enables for the level requests |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ack | input | 1 | Core accepts the presented vector |
| cmd_sei | input | 1 | Set global enable |
| cmd_cli | input | 1 | Clear global enable |
| cmd_reti | input | 1 | Return from handler, sets global enable |
| irq_valid | output | 1 | A vector is being presented |
| irq_vec | output | VEC_W (4) | Presented vector number |
| irq_addr | output | ADDR_W (12) | Handler program address |
| gie | output | 1 | Global enable state |

## Verification
The bench keeps the default source counts (two external, five timer, five level), so all thirteen vectors and every priority pair between them can be reached. It overrides the vector stride to 2 and the base to 16. An address formula that ignored either parameter therefore gives a visibly wrong handler address. Because the register widths stay below eight bits, random writes of full bytes also exercise the rule that unused bits read as 0.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_DW = 8;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_EXT_MASK = 2'd0,
        RA_EXT_FLAG = 2'd1,
        RA_TMR_MASK = 2'd2,
        RA_TMR_FLAG = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         flag_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] flag_o
);

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] flag;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (mask_we)
            b_d.mask = wdata;
        // write-one clear and acknowledge clear; a fresh event always wins
        b_d.flag = (b_q.flag & ~(flag_we ? wdata : '0) & ~ack_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            b_q <= '0;
        else
            b_q <= b_d;
    end

    assign mask_o = b_q.mask;
    assign flag_o = b_q.flag;

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flag_o & $past(evt)) == $past(evt))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && ack_clr == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R2

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        // scan downwards so that the lowest set index is left in idx
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_EXT    = 2,
    parameter int NUM_TMR    = 5,
    parameter int NUM_LVL    = 5,
    parameter int ADDR_W     = 12,
    parameter int VEC_BASE   = 0,
    parameter int VEC_STRIDE = 1,
    localparam int N_VEC     = 1 + NUM_EXT + NUM_TMR + NUM_LVL,
    localparam int VEC_W     = $clog2(N_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    input  logic [NUM_EXT-1:0] ext_evt,
    input  logic [NUM_TMR-1:0] tmr_evt,
    input  logic [NUM_LVL-1:0] lvl_req,
    input  logic [NUM_LVL-1:0] lvl_en,
    input  logic               boundary,
    input  logic               ack,
    input  logic               cmd_sei,
    input  logic               cmd_cli,
    input  logic               cmd_reti,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [ADDR_W-1:0]  irq_addr,
    output logic               gie
);

    localparam int EXT_V0 = 1;
    localparam int TMR_V0 = 1 + NUM_EXT;
    localparam int MAXW   = (NUM_EXT > NUM_TMR) ? NUM_EXT : NUM_TMR;

    typedef struct packed {
        logic             gie;
        logic             rst_pend;
        logic             valid;
        logic [VEC_W-1:0] vec;
    } core_t;

    core_t c_d, c_q;

    logic               ack_ok;
    logic [NUM_EXT-1:0] ext_mask, ext_flag, ext_ack;
    logic [NUM_TMR-1:0] tmr_mask, tmr_flag, tmr_ack;
    logic [N_VEC-1:0]   cand;
    logic               cand_any;
    logic [VEC_W-1:0]   cand_idx;
    logic               wdata_unused;

    assign ack_ok       = ack && c_q.valid;
    assign wdata_unused = ^(reg_wdata >> MAXW);

    // acknowledge clears, one per flagged source
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext_ack
        assign ext_ack[i] = ack_ok && (c_q.vec == VEC_W'(EXT_V0 + i));
    end
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr_ack
        assign tmr_ack[i] = ack_ok && (c_q.vec == VEC_W'(TMR_V0 + i));
    end

    irq_flag_bank #(.W(NUM_EXT)) i_ext_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (reg_we && reg_addr == RA_EXT_MASK),
        .flag_we (reg_we && reg_addr == RA_EXT_FLAG),
        .wdata   (reg_wdata[NUM_EXT-1:0]),
        .evt     (ext_evt),
        .ack_clr (ext_ack),
        .mask_o  (ext_mask),
        .flag_o  (ext_flag)
    );

    irq_flag_bank #(.W(NUM_TMR)) i_tmr_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (reg_we && reg_addr == RA_TMR_MASK),
        .flag_we (reg_we && reg_addr == RA_TMR_FLAG),
        .wdata   (reg_wdata[NUM_TMR-1:0]),
        .evt     (tmr_evt),
        .ack_clr (tmr_ack),
        .mask_o  (tmr_mask),
        .flag_o  (tmr_flag)
    );

    // candidate vector: bit 0 is reset and ignores the global enable
    assign cand = {c_q.gie ? {lvl_req & lvl_en, tmr_flag & tmr_mask, ext_flag & ext_mask}
                           : {(N_VEC-1){1'b0}},
                   c_q.rst_pend};

    irq_prio_enc #(.N(N_VEC), .IW(VEC_W)) i_prio (
        .req (cand),
        .any (cand_any),
        .idx (cand_idx)
    );

    always_comb begin
        c_d = c_q;
        if (ack_ok) begin
            c_d.valid = 1'b0;
            if (c_q.vec == '0)
                c_d.rst_pend = 1'b0;
        end else if (boundary) begin
            c_d.valid = cand_any;
            if (cand_any)
                c_d.vec = cand_idx;
        end
        if (ack_ok || cmd_cli)
            c_d.gie = 1'b0;
        else if (cmd_sei || cmd_reti)
            c_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '{gie: 1'b0, rst_pend: 1'b1, valid: 1'b0, vec: '0};
        else
            c_q <= c_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_EXT_MASK: reg_rdata[NUM_EXT-1:0] = ext_mask;
            RA_EXT_FLAG: reg_rdata[NUM_EXT-1:0] = ext_flag;
            RA_TMR_MASK: reg_rdata[NUM_TMR-1:0] = tmr_mask;
            default:     reg_rdata[NUM_TMR-1:0] = tmr_flag;
        endcase
    end

    assign irq_valid = c_q.valid;
    assign irq_vec   = c_q.vec;
    assign irq_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(c_q.vec) * ADDR_W'(VEC_STRIDE);
    assign gie       = c_q.gie;

    AST_RISE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(boundary)); // R5

    AST_RISE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && irq_vec != '0) |-> $past(gie)); // R5

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid) |=> (!irq_valid && !gie)); // R8

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_vec) < N_VEC)); // R6

    AST_CLI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cli |=> !gie); // R10

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/100ps
module test_irq_vector_ctrl;

    localparam int NE = 2, NT = 5, NL = 5;
    localparam int BASE = 16, STRIDE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [NE-1:0] ext_evt = '0;
    logic [NT-1:0] tmr_evt = '0;
    logic [NL-1:0] lvl_req = '0;
    logic [NL-1:0] lvl_en = '0;
    logic boundary = 1'b0, ack = 1'b0, cmd_sei = 1'b0, cmd_cli = 1'b0, cmd_reti = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_vec;
    logic [11:0] irq_addr;
    logic        gie;

    int checks = 0, failures = 0;
    bit done = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.NUM_EXT(NE), .NUM_TMR(NT), .NUM_LVL(NL), .ADDR_W(12),
                      .VEC_BASE(BASE), .VEC_STRIDE(STRIDE)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
        .tmr_evt(tmr_evt), .lvl_req(lvl_req), .lvl_en(lvl_en), .boundary(boundary),
        .ack(ack), .cmd_sei(cmd_sei), .cmd_cli(cmd_cli), .cmd_reti(cmd_reti),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_addr(irq_addr), .gie(gie));

    // behavioural reference model
    int m_emask, m_eflag, m_tmask, m_tflag, m_vec, win, clr_e, clr_t;
    bit m_gie, m_rst, m_valid, ack_ok;

    function automatic bit pend(int v);
        if (v <= NE) return m_eflag[v-1] & m_emask[v-1];
        if (v <= NE + NT) return m_tflag[v-1-NE] & m_tmask[v-1-NE];
        return lvl_req[v-1-NE-NT] & lvl_en[v-1-NE-NT];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_emask = 0; m_eflag = 0; m_tmask = 0; m_tflag = 0;
            m_gie = 0; m_rst = 1; m_valid = 0; m_vec = 0;
        end else begin
            ack_ok = ack && m_valid;
            win = -1;
            if (m_rst) win = 0;
            else if (m_gie)
                for (int v = 12; v >= 1; v--) if (pend(v)) win = v;
            clr_e = (reg_we && reg_addr == 1) ? int'(reg_wdata) : 0;
            clr_t = (reg_we && reg_addr == 3) ? int'(reg_wdata) : 0;
            if (ack_ok && m_vec >= 1 && m_vec <= NE) clr_e = clr_e | (1 << (m_vec - 1));
            if (ack_ok && m_vec > NE && m_vec <= NE + NT) clr_t = clr_t | (1 << (m_vec - 1 - NE));
            m_eflag = ((m_eflag & ~clr_e) | int'(ext_evt)) & 3;
            m_tflag = ((m_tflag & ~clr_t) | int'(tmr_evt)) & 31;
            if (reg_we && reg_addr == 0) m_emask = int'(reg_wdata) & 3;
            if (reg_we && reg_addr == 2) m_tmask = int'(reg_wdata) & 31;
            if (ack_ok || cmd_cli) m_gie = 0;
            else if (cmd_sei || cmd_reti) m_gie = 1;
            if (ack_ok) begin
                if (m_vec == 0) m_rst = 0;
                m_valid = 0;
            end else if (boundary) begin
                m_valid = (win >= 0);
                if (win >= 0) m_vec = win;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (phase %s) act=%0d exp=%0d t=%0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        check("R5 valid", int'(irq_valid), int'(m_valid));
        check("R10 gie", int'(gie), int'(m_gie));
        if (m_valid) begin
            check("R6 vec", int'(irq_vec), m_vec);
            check("R7 addr", int'(irq_addr), (BASE + m_vec * STRIDE) & 12'hFFF);
        end
        case (reg_addr)
            2'd0: exp_rd = m_emask;
            2'd1: exp_rd = m_eflag;
            2'd2: exp_rd = m_tmask;
            default: exp_rd = m_tflag;
        endcase
        check((reg_addr[0]) ? "R2 flag read" : "R4 mask read", int'(reg_rdata), exp_rd);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        reg_we = 0; ext_evt = '0; tmr_evt = '0; boundary = 0; ack = 0;
        cmd_sei = 0; cmd_cli = 0; cmd_reti = 0;
    endtask

    task automatic wr(int a, int d);
        reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(d); tick();
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, then reset vector despite gie=0
        phase = "R1";
        tick();
        check("R1 reset valid", int'(irq_valid), 0);
        check("R1 reset gie", int'(gie), 0);
        boundary = 1; tick();
        check("R1 reset vector", int'(irq_vec), 0);
        ack = 1; tick();
        boundary = 1; tick();
        check("R1 reset retired", int'(irq_valid), 0);
        // R4: masks keep only their implemented bits
        phase = "R4";
        wr(0, 8'hFF); reg_addr = 0; tick();
        check("R4 ext mask width", int'(reg_rdata), 3);
        wr(2, 8'hFF); reg_addr = 2; tick();
        wr(2, 0); wr(0, 0);
        // R2: events latch while masked
        phase = "R2";
        tmr_evt = 5'b10000; ext_evt = 2'b01; reg_addr = 3; tick();
        tick();
        check("R2 masked latch", int'(reg_rdata), 16);
        // R3: write zero keeps, write one clears, event wins over clear
        phase = "R3";
        wr(3, 0); reg_addr = 3; tick();
        check("R3 zero write", int'(reg_rdata), 16);
        wr(3, 16); reg_addr = 3; tick();
        check("R3 one write", int'(reg_rdata), 0);
        reg_we = 1; reg_addr = 1; reg_wdata = 8'h01; ext_evt = 2'b01; tick();
        reg_addr = 1; tick();
        check("R3 event wins", int'(reg_rdata), 1);
        // R10: command precedence
        phase = "R10";
        cmd_sei = 1; tick();
        cmd_cli = 1; cmd_sei = 1; tick();
        check("R10 cli beats sei", int'(gie), 0);
        cmd_reti = 1; tick();
        check("R10 reti sets", int'(gie), 1);
        // R6: ext1 (vector 2) beats timer 0 (vector 3)
        phase = "R6";
        wr(1, 3); wr(0, 2); wr(2, 1);
        ext_evt = 2'b10; tmr_evt = 5'b00001; tick();
        boundary = 1; tick();
        check("R6 priority", int'(irq_vec), 2);
        // R8: ack clears gie and flag; stray ack ignored
        phase = "R8";
        ack = 1; reg_addr = 1; tick();
        check("R8 flag cleared", int'(reg_rdata), 0);
        check("R8 gie cleared", int'(gie), 0);
        ack = 1; tick();
        // R9: level request re-presented after ack
        phase = "R9";
        wr(2, 0);
        lvl_req = 5'b00100; lvl_en = 5'b00100;
        cmd_sei = 1; tick();
        boundary = 1; tick();
        check("R9 level vector", int'(irq_vec), 10);
        ack = 1; tick();
        cmd_reti = 1; tick();
        boundary = 1; tick();
        check("R9 level again", int'(irq_vec), 10);
        ack = 1; tick();
        // R5 and all others under random stimulus
        phase = "R5";
        for (int n = 0; n < 6000; n++) begin
            reg_addr = 2'($urandom);
            if ($urandom_range(0, 5) == 0) begin reg_we = 1; reg_wdata = 8'($urandom); end
            if ($urandom_range(0, 7) == 0) ext_evt = 2'($urandom);
            if ($urandom_range(0, 7) == 0) tmr_evt = 5'($urandom);
            if ($urandom_range(0, 9) == 0) lvl_req = 5'($urandom);
            if ($urandom_range(0, 19) == 0) lvl_en = 5'($urandom);
            boundary = ($urandom_range(0, 2) == 0);
            ack = ($urandom_range(0, 2) == 0);
            cmd_sei = ($urandom_range(0, 9) == 0);
            cmd_cli = ($urandom_range(0, 14) == 0);
            cmd_reti = ($urandom_range(0, 9) == 0);
            tick();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule